// File: doc/BRIEF.md
# Sixteen-Operation Arithmetic and Logic Unit

This block is the datapath arithmetic unit of a small eight-register processor. Each cycle it receives two 16-bit operands, a 4-bit operation code, a 2-bit carry-in select and the stored carry flag. From these it produces a 16-bit result, a zero flag and a carry flag.

The block has no storage, so every output follows its inputs within the same cycle. The surrounding core owns operand selection, the register file and the flag register. The core builds bitwise complement and two's-complement negation by issuing a subtract with a zero first operand. It picks between the two results through the carry-in select.

Operations: arithmetic (add, subtract, multiply, divide), bitwise logic (AND, OR, XOR), pass-through of the first operand, and eight shifts. The shifts come from two directions combined with four fill modes.

Top module: `alu16_core`

## Requirements
- R1: Code 0 (add) gives result = A + B + cin, modulo 2^16. C is the carry out of bit 15.
- R2: Code 1 (subtract) gives result = A − B − cin, modulo 2^16. C is set when a borrow leaves bit 15. With A = 0, cin = 1 gives the bitwise complement of B, and cin = 0 gives the negation of B.
- R3: The carry-in select chooses cin as follows: 0 gives constant 0, 1 gives constant 1, 2 gives the stored carry flag, and 3 gives its inverse. The select affects only add and subtract.
- R4: Code 2 (multiply) returns the low 16 bits of the unsigned product A × B, with C cleared.
- R5: Code 3 (divide) returns the unsigned quotient A / B, with C cleared. When B = 0 it returns 16'hFFFF with C set.
- R6: Codes 4, 5 and 6 give A AND B, A OR B and A XOR B. Code 7 passes A through unchanged. C is cleared for all four codes.
- R7: Codes 8 to F are shifts. Code bit 2 selects the direction (0 = left, 1 = right). The shift amount is B[3:0], and B[15:4] has no effect.
- R8: Code bits 1:0 select the fill for vacated positions: 00 fills with zeros and 01 fills with ones. 10 fills with copies of the end bit the data moves away from (bit 0 for a left shift, bit 15 for a right shift). 11 rotates the data so that bits leaving one end enter the other.
- R9: For a shift by n > 0, C holds the last bit moved past the end: A[16−n] for a left shift and A[n−1] for a right shift. A shift by 0 returns A with C cleared.
- R10: Z is set exactly when the 16-bit result is all zeros, for every operation.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| opnd_a | input | 16 | First operand |
| opnd_b | input | 16 | Second operand, which also carries the shift amount |
| op_code | input | 4 | Operation select |
| cin_sel | input | 2 | Carry-in source select |
| carry_flag | input | 1 | Stored carry flag from the core |
| result | output | 16 | Operation result |
| zero_out | output | 1 | Zero flag |
| carry_out | output | 1 | Carry, borrow, divide-by-zero or shifted-out bit |

## Verification
The zero flag and the carry flag are both set in the same evaluation in several cases. An add can wrap to zero with a carry out, for example FFFF + 0001 or 8000 + 8000. A subtract with borrow can wrap to zero, for example 0000 − FFFF − 1. A shift can push every set bit out of the word while the last bit lost is a one. The directed tasks drive these operand pairs, and the random sweep meets further cases. For each case the bench compares result, Z and C together against an independent reference, so a flag that is wrongly masked by the other shows up as a mismatch.

// File: rtl/alu16_pkg.sv
package alu16_pkg;

    typedef enum logic [3:0] {
        OP_ADD  = 4'h0,
        OP_SUB  = 4'h1,
        OP_MUL  = 4'h2,
        OP_DIV  = 4'h3,
        OP_AND  = 4'h4,
        OP_OR   = 4'h5,
        OP_XOR  = 4'h6,
        OP_PASS = 4'h7,
        OP_SLZ  = 4'h8,
        OP_SLO  = 4'h9,
        OP_SLE  = 4'hA,
        OP_SLR  = 4'hB,
        OP_SRZ  = 4'hC,
        OP_SRO  = 4'hD,
        OP_SRE  = 4'hE,
        OP_SRR  = 4'hF
    } alu_op_e;

    typedef enum logic [1:0] {
        CIN_ZERO = 2'd0,
        CIN_ONE  = 2'd1,
        CIN_FLAG = 2'd2,
        CIN_INV  = 2'd3
    } cin_src_e;

    typedef enum logic [1:0] {
        FILL_ZERO = 2'b00,
        FILL_ONE  = 2'b01,
        FILL_EDGE = 2'b10,
        FILL_ROT  = 2'b11
    } fill_e;

endpackage

// File: rtl/alu16_addsub.sv
module alu16_addsub #(
    parameter int W = 16
) (
    input  logic [W-1:0] a_i,
    input  logic [W-1:0] b_i,
    input  logic         sub_i,
    input  logic         cin_i,
    output logic [W-1:0] sum_o,
    output logic         flag_o
);

    always_comb begin
        logic c;
        logic bb;
        c = sub_i ? ~cin_i : cin_i;
        sum_o = '0;
        for (int i = 0; i < W; i++) begin
            bb = sub_i ? ~b_i[i] : b_i[i];
            sum_o[i] = a_i[i] ^ bb ^ c;
            c = (a_i[i] & bb) | (a_i[i] & c) | (bb & c);
        end
        flag_o = sub_i ? ~c : c;

        // R1
        addsub_add_chk: assert (sub_i || {flag_o, sum_o} ==
            ((W+1)'(a_i) + (W+1)'(b_i) + (W+1)'(cin_i)));
        // R2
        addsub_sub_chk: assert (!sub_i || {flag_o, sum_o} ==
            ((W+1)'(a_i) - (W+1)'(b_i) - (W+1)'(cin_i)));
    end

endmodule

// File: rtl/alu16_shifter.sv
module alu16_shifter
    import alu16_pkg::*;
#(
    parameter int W  = 16,
    localparam int AW = $clog2(W)
) (
    input  logic [W-1:0]  a_i,
    input  logic [AW-1:0] amt_i,
    input  logic          dir_i,
    input  logic [1:0]    fill_i,
    output logic [W-1:0]  res_o,
    output logic          cout_o
);

    always_comb begin
        res_o  = '0;
        cout_o = 1'b0;
        for (int i = 0; i < W; i++) begin
            int src;
            src = dir_i ? (i + int'(amt_i)) : (i - int'(amt_i));
            if (src >= 0 && src < W) begin
                res_o[i] = a_i[AW'(src)];
            end else begin
                unique case (fill_e'(fill_i))
                    FILL_ZERO: res_o[i] = 1'b0;
                    FILL_ONE:  res_o[i] = 1'b1;
                    FILL_EDGE: res_o[i] = dir_i ? a_i[W-1] : a_i[0];
                    FILL_ROT:  res_o[i] = a_i[AW'(src)];
                endcase
            end
        end
        if (amt_i != '0) begin
            cout_o = dir_i ? a_i[amt_i - 1'b1] : a_i[AW'(W - int'(amt_i))];
        end

        // R9
        shift_zero_amt_chk: assert (amt_i != '0 || (res_o == a_i && !cout_o));
        // R8
        shift_rot_chk: assert (fill_i != 2'b11 ||
            $countones(res_o) == $countones(a_i));
    end

endmodule

// File: rtl/alu16_divider.sv
module alu16_divider #(
    parameter int W = 16
) (
    input  logic [W-1:0] num_i,
    input  logic [W-1:0] den_i,
    output logic [W-1:0] quo_o,
    output logic         dz_o
);

    logic [W:0] rem;

    always_comb begin
        rem   = '0;
        quo_o = '0;
        for (int i = W - 1; i >= 0; i--) begin
            rem = {rem[W-1:0], num_i[i]};
            if (rem >= {1'b0, den_i}) begin
                rem      = rem - {1'b0, den_i};
                quo_o[i] = 1'b1;
            end
        end
        dz_o = (den_i == '0);

        // R5
        div_residue_chk: assert (dz_o ||
            ((2*W)'(quo_o) * (2*W)'(den_i) + (2*W)'(rem) == (2*W)'(num_i)
             && rem < {1'b0, den_i}));
        // R5
        div_zero_chk: assert (!dz_o || quo_o == '1);
    end

endmodule

// File: rtl/alu16_core.sv
module alu16_core
    import alu16_pkg::*;
#(
    parameter int W  = 16,
    localparam int AW = $clog2(W)
) (
    input  logic [W-1:0] opnd_a,
    input  logic [W-1:0] opnd_b,
    input  logic [3:0]   op_code,
    input  logic [1:0]   cin_sel,
    input  logic         carry_flag,
    output logic [W-1:0] result,
    output logic         zero_out,
    output logic         carry_out
);

    logic         cin;
    logic [W-1:0] as_sum;
    logic         as_flag;
    logic [W-1:0] sh_res;
    logic         sh_cout;
    logic [W-1:0] dv_quo;
    logic         dv_zero;
    logic [W-1:0] mul_lo;

    always_comb begin
        unique case (cin_src_e'(cin_sel))
            CIN_ZERO: cin = 1'b0;
            CIN_ONE:  cin = 1'b1;
            CIN_FLAG: cin = carry_flag;
            CIN_INV:  cin = ~carry_flag;
        endcase
    end

    alu16_addsub #(.W(W)) u_addsub (
        .a_i    (opnd_a),
        .b_i    (opnd_b),
        .sub_i  (op_code == OP_SUB),
        .cin_i  (cin),
        .sum_o  (as_sum),
        .flag_o (as_flag)
    );

    alu16_shifter #(.W(W)) u_shifter (
        .a_i    (opnd_a),
        .amt_i  (opnd_b[AW-1:0]),
        .dir_i  (op_code[2]),
        .fill_i (op_code[1:0]),
        .res_o  (sh_res),
        .cout_o (sh_cout)
    );

    alu16_divider #(.W(W)) u_divider (
        .num_i (opnd_a),
        .den_i (opnd_b),
        .quo_o (dv_quo),
        .dz_o  (dv_zero)
    );

    assign mul_lo = opnd_a * opnd_b;

    always_comb begin
        result    = '0;
        carry_out = 1'b0;
        unique case (alu_op_e'(op_code))
            OP_ADD, OP_SUB: begin
                result    = as_sum;
                carry_out = as_flag;
            end
            OP_MUL:  result = mul_lo;
            OP_DIV: begin
                result    = dv_quo;
                carry_out = dv_zero;
            end
            OP_AND:  result = opnd_a & opnd_b;
            OP_OR:   result = opnd_a | opnd_b;
            OP_XOR:  result = opnd_a ^ opnd_b;
            OP_PASS: result = opnd_a;
            default: begin
                result    = sh_res;
                carry_out = sh_cout;
            end
        endcase
        zero_out = (result == '0);
    end

endmodule

// File: tb/alu16_core_bench.sv
module alu16_core_bench;

    logic        clk = 1'b0;
    logic [15:0] a, b;
    logic [3:0]  op;
    logic [1:0]  csel;
    logic        cflag;
    logic [15:0] res;
    logic        zf, cf;
    int          n_chk = 0;
    int          n_bad = 0;
    bit          done  = 1'b0;
    logic [31:0] lfsr  = 32'hACE1_2357;

    always #2 clk = ~clk;

    alu16_core u_alu16_core (
        .opnd_a(a), .opnd_b(b), .op_code(op), .cin_sel(csel),
        .carry_flag(cflag), .result(res), .zero_out(zf), .carry_out(cf)
    );

    function automatic void ref_alu(input logic [3:0] o, input logic [15:0] x,
                                    input logic [15:0] y, input logic [1:0] s,
                                    input logic f, output logic [15:0] r,
                                    output logic c);
        logic ci;
        int   n;
        logic [31:0] t;
        ci = (s == 2'd0) ? 1'b0 : (s == 2'd1) ? 1'b1 : (s == 2'd2) ? f : ~f;
        n  = int'(y[3:0]);
        c  = 1'b0;
        r  = 16'h0;
        case (o)
            4'h0: begin t = 32'(x) + 32'(y) + 32'(ci); r = t[15:0]; c = t[16]; end
            4'h1: begin
                r = x - y - 16'(ci);
                c = (32'(x) < 32'(y) + 32'(ci));
            end
            4'h2: begin t = 32'(x) * 32'(y); r = t[15:0]; end
            4'h3: begin
                if (y == 0) begin r = 16'hFFFF; c = 1'b1; end
                else r = x / y;
            end
            4'h4: r = x & y;
            4'h5: r = x | y;
            4'h6: r = x ^ y;
            4'h7: r = x;
            default: begin
                if (n == 0) begin
                    r = x;
                end else if (!o[2]) begin
                    t = {x, x} << n;
                    case (o[1:0])
                        2'b00: r = x << n;
                        2'b01: r = (x << n) | 16'((32'h1 << n) - 1);
                        2'b10: r = x[0] ? ((x << n) | 16'((32'h1 << n) - 1)) : (x << n);
                        default: r = t[31:16];
                    endcase
                    c = x[16-n];
                end else begin
                    t = {x, x} >> n;
                    case (o[1:0])
                        2'b00: r = x >> n;
                        2'b01: r = (x >> n) | ~(16'hFFFF >> n);
                        2'b10: r = 16'($signed(x) >>> n);
                        default: r = t[15:0];
                    endcase
                    c = x[n-1];
                end
            end
        endcase
    endfunction

    task automatic apply(input logic [3:0] o, input logic [15:0] x,
                         input logic [15:0] y, input logic [1:0] s,
                         input logic f, input string tag);
        logic [15:0] er;
        logic        ec;
        @(negedge clk);
        op = o; a = x; b = y; csel = s; cflag = f;
        @(posedge clk);
        #1;
        ref_alu(o, x, y, s, f, er, ec);
        n_chk++;
        if (res !== er || zf !== (er == 16'h0) || cf !== ec) begin
            n_bad++;
            $display("FAIL %s op=%h a=%h b=%h sel=%0d f=%b: got r=%h z=%b c=%b exp r=%h z=%b c=%b",
                     tag, o, x, y, s, f, res, zf, cf, er, (er == 16'h0), ec);
        end
    endtask

    function automatic logic [15:0] rnd16();
        lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
        lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
        return lfsr[15:0] ^ lfsr[31:16];
    endfunction

    task automatic t_idle();
        apply(4'h0, 16'h0, 16'h0, 2'd0, 1'b0, "R10 idle zero");
    endtask

    task automatic t_add();
        apply(4'h0, 16'h1234, 16'h4321, 2'd0, 1'b0, "R1 add");
        apply(4'h0, 16'hFFFF, 16'h0001, 2'd0, 1'b0, "R1 R10 add wrap");
        apply(4'h0, 16'h8000, 16'h8000, 2'd0, 1'b0, "R1 R10 add wrap2");
        apply(4'h0, 16'hFFFF, 16'h0000, 2'd1, 1'b0, "R1 add cin");
    endtask

    task automatic t_sub();
        apply(4'h1, 16'h5000, 16'h1000, 2'd0, 1'b0, "R2 sub");
        apply(4'h1, 16'h0001, 16'h0002, 2'd0, 1'b0, "R2 sub borrow");
        apply(4'h1, 16'h0000, 16'hA5C3, 2'd1, 1'b0, "R2 not");
        apply(4'h1, 16'h0000, 16'h0001, 2'd0, 1'b0, "R2 neg");
        apply(4'h1, 16'h0000, 16'h0000, 2'd0, 1'b0, "R2 neg zero");
        apply(4'h1, 16'h0000, 16'hFFFF, 2'd1, 1'b0, "R2 R10 sub wrap");
    endtask

    task automatic t_csel();
        for (int s = 0; s < 4; s++) begin
            apply(4'h0, 16'h0010, 16'h0001, 2'(s), 1'b0, "R3 add sel");
            apply(4'h0, 16'h0010, 16'h0001, 2'(s), 1'b1, "R3 add sel");
            apply(4'h1, 16'h0010, 16'h0001, 2'(s), 1'b1, "R3 sub sel");
            apply(4'h4, 16'h00F0, 16'h0FF0, 2'(s), 1'b1, "R3 sel ignored");
        end
    endtask

    task automatic t_mul();
        apply(4'h2, 16'h0123, 16'h0045, 2'd1, 1'b1, "R4 mul");
        apply(4'h2, 16'hFFFF, 16'hFFFF, 2'd0, 1'b0, "R4 mul trunc");
        apply(4'h2, 16'h0100, 16'h0100, 2'd0, 1'b0, "R4 R10 mul zero");
    endtask

    task automatic t_div();
        apply(4'h3, 16'd1000, 16'd7, 2'd0, 1'b0, "R5 div");
        apply(4'h3, 16'hFFFF, 16'h0001, 2'd0, 1'b0, "R5 div one");
        apply(4'h3, 16'h0003, 16'h0009, 2'd0, 1'b0, "R5 div small");
        apply(4'h3, 16'h1234, 16'h0000, 2'd0, 1'b0, "R5 div by zero");
    endtask

    task automatic t_logic();
        apply(4'h4, 16'hF0F0, 16'hFF00, 2'd1, 1'b1, "R6 and");
        apply(4'h5, 16'hF0F0, 16'h0F00, 2'd1, 1'b1, "R6 or");
        apply(4'h6, 16'hAAAA, 16'hAAAA, 2'd1, 1'b1, "R6 xor");
        apply(4'h7, 16'hBEEF, 16'h1234, 2'd1, 1'b1, "R6 pass");
    endtask

    task automatic t_shift();
        for (int o = 8; o < 16; o++) begin
            apply(4'(o), 16'h8421, 16'h0003, 2'd0, 1'b0, "R7 R8 shift 3");
            apply(4'(o), 16'h7FFE, 16'h000F, 2'd0, 1'b0, "R8 R9 shift 15");
            apply(4'(o), 16'h8001, 16'h0001, 2'd0, 1'b0, "R8 R9 shift 1");
            apply(4'(o), 16'hC3A5, 16'hFFF0, 2'd0, 1'b0, "R7 R9 amount zero");
            apply(4'(o), 16'h1234, 16'hABC5, 2'd0, 1'b0, "R7 upper B ignored");
        end
        apply(4'h8, 16'h8000, 16'h0001, 2'd0, 1'b0, "R9 R10 shift out last");
        apply(4'hC, 16'h0001, 16'h0001, 2'd0, 1'b0, "R9 R10 shift out last");
    endtask

    task automatic t_random();
        for (int k = 0; k < 4000; k++) begin
            logic [15:0] x, y, s;
            x = rnd16(); y = rnd16(); s = rnd16();
            if (s[15:13] == 3'b000) y = 16'h0;
            apply(s[3:0], x, y, s[5:4], s[6], "R1 R5 R8 R10 random");
        end
    endtask

    initial begin
        a = '0; b = '0; op = '0; csel = '0; cflag = 1'b0;
        repeat (2) @(posedge clk);
        t_idle();
        t_add();
        t_sub();
        t_csel();
        t_mul();
        t_div();
        t_logic();
        t_shift();
        t_random();
        if (!done) begin
            done = 1'b1;
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end

    initial begin
        #(4 * 150000);
        if (!done) begin
            done = 1'b1;
            n_chk++;
            n_bad++;
            $display("FAIL watchdog expired");
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end

endmodule